// File: doc/BRIEF.md
# Peripheral Clock Gate Controller

The block gates a single peripheral clock. Ownership of the gate belongs either to software or to a hardware request line, and a select input chooses the owner. When software owns the gate, its enable bit decides whether the clock runs. When hardware owns it, a request input decides, and the software enable has no effect. The block drives the clock-enable output and a status bit. The status bit follows the enable one cycle later, so software can poll it until it matches the state it asked for.

Turning the clock on is fast. Turning it off goes through a drain phase whose length depends on two hysteresis controls. With hysteresis disabled, the phase is short. With it enabled, a value bit picks a short or a long programmable delay. If the request returns while the drain is still counting, the turn-off is abandoned and the clock keeps running. A build-time no-disable option forces the clock on permanently, whatever the owner or the enable bit says.

Top module: `clk_gate_ctrl`

## Requirements
- R1: With NO_DISABLE=0, clk_en_o and status_o are 0 while rst_ni is low. They stay 0 after release until a request is sampled.
- R2: When sw_sel_i=1 (software owner), the effective request equals sw_en_i, and hw_req_i has no effect on clk_en_o.
- R3: When sw_sel_i=0 (hardware owner), the effective request equals hw_req_i, and sw_en_i has no effect on clk_en_o.
- R4: If the gate is off and a request is sampled at clock edge k, clk_en_o is 1 after edge k.
- R5: status_o always equals the value clk_en_o had one cycle earlier. It therefore becomes 1 after edge k+1 on turn-on and falls one cycle after clk_en_o on turn-off.
- R6: With hyst_en_i=0, the request drop is first sampled at edge k. clk_en_o falls at edge k+2, whatever the value of hyst_hi_i.
- R7: With hyst_en_i=1 and hyst_hi_i=0, clk_en_o falls at edge k+HYST_LO (default 8).
- R8: With hyst_en_i=1 and hyst_hi_i=1, clk_en_o falls at edge k+HYST_HI (default 64).
- R9: The delay is chosen from hyst_en_i and hyst_hi_i as sampled at edge k. Changing them later does not alter a turn-off already under way.
- R10: If the request is sampled high again at any edge up to and including k+D, where D is the selected delay, the turn-off is cancelled. clk_en_o and status_o stay 1, and a later drop restarts the full delay.
- R11: With NO_DISABLE=1, clk_en_o is 1 at all times, regardless of the owner, the enable bit and the hardware request. status_o is 1 from the second edge after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_sel_i | input | 1 | Owner select: 1 software, 0 hardware |
| sw_en_i | input | 1 | Software enable bit |
| hw_req_i | input | 1 | Hardware clock request |
| hyst_en_i | input | 1 | Turn-off hysteresis enable |
| hyst_hi_i | input | 1 | Hysteresis length: 0 short, 1 long |
| clk_en_o | output | 1 | Clock-enable to the gate cell |
| status_o | output | 1 | Actual gate state, one cycle behind clk_en_o |

## Verification
The bench sweeps all eight combinations of owner select, software enable and hardware request, starting from the off state. This separates a correct owner mux from one that reads the wrong source or ORs the two sources. The bench measures the turn-off latency in each hysteresis setting and under both owners, which exposes swapped or off-by-one delay counts. It also changes the hysteresis inputs in the middle of a count. Re-requests early in the drain and at its last edge show whether the cancel path is taken. A second instance built with no-disable is watched on every cycle while the first instance receives all of the stimulus.

// File: rtl/gate_pkg.sv
package gate_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ON    = 2'd1,
    ST_DRAIN = 2'd2
  } gate_state_e;

endpackage

// File: rtl/gate_req_sel.sv
module gate_req_sel #(
  parameter bit NO_DISABLE = 1'b0
) (
  input  logic sw_sel_i,
  input  logic sw_en_i,
  input  logic hw_req_i,
  output logic req_o
);

  generate
    if (NO_DISABLE) begin : g_pinned
      logic unused_in;
      assign unused_in = sw_sel_i ^ sw_en_i ^ hw_req_i;
      assign req_o     = 1'b1;
    end else begin : g_owner_mux
      assign req_o = sw_sel_i ? sw_en_i : hw_req_i;
    end
  endgenerate

endmodule

// File: rtl/gate_off_timer.sv
module gate_off_timer #(
  parameter int unsigned HYST_LO = 8,
  parameter int unsigned HYST_HI = 64,
  parameter int unsigned CNT_W   = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic hyst_en_i,
  input  logic hyst_hi_i,
  input  logic dec_i,
  output logic zero_o
);

  // load value is delay-1: zero is seen at edge k+D
  localparam logic [CNT_W-1:0] LD_NONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] LD_LO   = CNT_W'(HYST_LO - 1);
  localparam logic [CNT_W-1:0] LD_HI   = CNT_W'(HYST_HI - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ld_val;

  always_comb begin
    if (!hyst_en_i)     ld_val = LD_NONE;
    else if (hyst_hi_i) ld_val = LD_HI;
    else                ld_val = LD_LO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= ld_val;
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_LOAD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q != '0 && int'(cnt_q) < int'(HYST_HI))); // R8

endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
  import gate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic zero_i,
  input  logic en_i,
  output logic load_o,
  output logic dec_o,
  output logic active_o,
  output logic status_o
);

  gate_state_e state_q, state_d;
  logic        status_q;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    dec_o   = 1'b0;
    unique case (state_q)
      ST_OFF: if (req_i) state_d = ST_ON;
      ST_ON: if (!req_i) begin
        state_d = ST_DRAIN;
        load_o  = 1'b1;
      end
      ST_DRAIN: begin
        if (req_i)       state_d = ST_ON;  // cancel pending turn-off
        else if (zero_i) state_d = ST_OFF;
        else             dec_o   = 1'b1;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_OFF;
      status_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      status_q <= en_i;
    end
  end

  assign active_o = (state_q != ST_OFF);
  assign status_o = status_q;

  AST_CANCEL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN && req_i) |=> (state_q == ST_ON && status_o)); // R10

endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl #(
  parameter bit          NO_DISABLE = 1'b0,
  parameter int unsigned HYST_LO    = 8,   // >= 2
  parameter int unsigned HYST_HI    = 64   // >= HYST_LO
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_sel_i,
  input  logic sw_en_i,
  input  logic hw_req_i,
  input  logic hyst_en_i,
  input  logic hyst_hi_i,
  output logic clk_en_o,
  output logic status_o
);

  localparam int unsigned CNT_W = (HYST_HI > 2) ? $clog2(HYST_HI) : 1;

  logic req, load, dec, zero, active, gate_en;

  gate_req_sel #(.NO_DISABLE(NO_DISABLE)) u_sel (
    .sw_sel_i (sw_sel_i),
    .sw_en_i  (sw_en_i),
    .hw_req_i (hw_req_i),
    .req_o    (req)
  );

  gate_off_timer #(.HYST_LO(HYST_LO), .HYST_HI(HYST_HI), .CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .hyst_en_i (hyst_en_i),
    .hyst_hi_i (hyst_hi_i),
    .dec_i     (dec),
    .zero_o    (zero)
  );

  gate_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .zero_i   (zero),
    .en_i     (gate_en),
    .load_o   (load),
    .dec_o    (dec),
    .active_o (active),
    .status_o (status_o)
  );

  generate
    if (NO_DISABLE) begin : g_pinned_on
      logic unused_active;
      assign unused_active = active;
      assign gate_en       = 1'b1;
    end else begin : g_follow
      assign gate_en = active;
    end
  endgenerate

  assign clk_en_o = gate_en;

  AST_ON_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && !clk_en_o) |=> clk_en_o); // R4

  AST_STATUS_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_o == $past(clk_en_o))); // R5

  AST_OFF_NOT_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_en_o) |-> (!$past(req) && !$past(req, 2))); // R6

endmodule

// File: tb/clk_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_gate_ctrl_tb_top;

  localparam int HLO = 8;
  localparam int HHI = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_sel = 1'b1, sw_en = 1'b0, hw_req = 1'b0, hyst_en = 1'b0, hyst_hi = 1'b0;
  logic en, status, nd_en, nd_status;
  int n_chk = 0, n_fail = 0, nd_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  clk_gate_ctrl #(.NO_DISABLE(1'b0), .HYST_LO(HLO), .HYST_HI(HHI)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sw_sel_i(sw_sel), .sw_en_i(sw_en), .hw_req_i(hw_req),
    .hyst_en_i(hyst_en), .hyst_hi_i(hyst_hi), .clk_en_o(en), .status_o(status));

  clk_gate_ctrl #(.NO_DISABLE(1'b1), .HYST_LO(HLO), .HYST_HI(HHI)) dut_nd_i (
    .clk_i(clk), .rst_ni(rst_n), .sw_sel_i(sw_sel), .sw_en_i(sw_en), .hw_req_i(hw_req),
    .hyst_en_i(hyst_en), .hyst_hi_i(hyst_hi), .clk_en_o(nd_en), .status_o(nd_status));

  always @(negedge clk) if (nd_en !== 1'b1) nd_err++;  // R11 watched every cycle

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_off();
    sw_sel = 1'b1; sw_en = 1'b0; hw_req = 1'b0; hyst_en = 1'b0; hyst_hi = 1'b0;
    wait_n(5);
  endtask

  task automatic go_on();
    sw_sel = 1'b1; sw_en = 1'b1; hyst_en = 1'b0; hyst_hi = 1'b0;
    wait_n(3);
  endtask

  // count negedges until en falls; edge k+D gives count D+1
  task automatic count_fall(output int cnt, input int start);
    cnt = start;
    while (en && cnt < 300) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic measure_off(input bit hen, input bit hhi, input int d, input string tag);
    int cnt;
    go_on();
    hyst_en = hen; hyst_hi = hhi; sw_en = 1'b0;
    count_fall(cnt, 0);
    chk({tag, " turn-off latency"}, cnt, d + 1);
    chk("R5 status lags fall", int'(status), 1);
    @(negedge clk);
    chk("R5 status follows fall", int'(status), 0);
  endtask

  initial begin
    int cnt;
    bit ok;
    wait_n(2);
    chk("R1 en in reset", int'(en), 0);
    chk("R1 status in reset", int'(status), 0);
    chk("R11 nd en in reset", int'(nd_en), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 en after release", int'(en), 0);
    chk("R1 status after release", int'(status), 0);
    @(negedge clk);
    chk("R11 nd status after reset", int'(nd_status), 1);

    // owner sweep from off
    for (int v = 0; v < 8; v++) begin
      bit s, e, h, exp;
      s = v[2]; e = v[1]; h = v[0];
      exp = s ? e : h;
      go_off();
      sw_sel = s; sw_en = e; hw_req = h;
      @(negedge clk);
      chk(s ? "R2 owner sw, R4 en" : "R3 owner hw, R4 en", int'(en), int'(exp));
      chk("R5 status still low", int'(status), 0);
      @(negedge clk);
      chk("R5 status after turn-on", int'(status), int'(exp));
    end

    measure_off(1'b0, 1'b0, 2, "R6");
    measure_off(1'b0, 1'b1, 2, "R6 hi ignored");
    measure_off(1'b1, 1'b0, HLO, "R7");
    measure_off(1'b1, 1'b1, HHI, "R8");

    // hardware owner turn-off, sw_en toggling must not matter
    go_off();
    sw_sel = 1'b0; hw_req = 1'b1; sw_en = 1'b0;
    wait_n(3);
    chk("R3 hw owner on", int'(en), 1);
    hyst_en = 1'b1; hyst_hi = 1'b0; hw_req = 1'b0; sw_en = 1'b1;
    count_fall(cnt, 0);
    chk("R3 R7 hw turn-off latency", cnt, HLO + 1);

    // R9: hysteresis change after edge k
    go_off();
    go_on();
    hyst_en = 1'b1; hyst_hi = 1'b1; sw_en = 1'b0;
    @(negedge clk);
    hyst_en = 1'b0; hyst_hi = 1'b0;
    count_fall(cnt, 1);
    chk("R9 delay latched at start", cnt, HHI + 1);

    // R10: early cancel then full restart
    go_on();
    hyst_en = 1'b1; hyst_hi = 1'b1; sw_en = 1'b0;
    wait_n(10);
    chk("R10 en during drain", int'(en), 1);
    sw_en = 1'b1;
    ok = 1'b1;
    repeat (80) begin
      @(negedge clk);
      if (!(en && status)) ok = 1'b0;
    end
    chk("R10 held after early cancel", int'(ok), 1);
    sw_en = 1'b0;
    count_fall(cnt, 0);
    chk("R10 full delay after cancel", cnt, HHI + 1);

    // R10: cancel on the last edge
    go_on();
    hyst_en = 1'b1; hyst_hi = 1'b0; sw_en = 1'b0;
    wait_n(HLO);
    chk("R10 en before last edge", int'(en), 1);
    sw_en = 1'b1;
    ok = 1'b1;
    repeat (12) begin
      @(negedge clk);
      if (!(en && status)) ok = 1'b0;
    end
    chk("R10 held after late cancel", int'(ok), 1);

    // R2: hw_req toggles under software owner with sw_en=0
    go_off();
    ok = 1'b1;
    repeat (6) begin
      hw_req = ~hw_req;
      @(negedge clk);
      if (en) ok = 1'b0;
    end
    chk("R2 hw_req ignored under sw owner", int'(ok), 1);

    chk("R11 nd en never low", nd_err, 0);
    chk("R11 nd status", int'(nd_status), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule